// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It runs on one fast input clock. All of its stages work in that one clock domain and pass timing to each other through single-cycle clock enables. A fixed divide-by-4 stage comes first. Its enable drives a dual-modulus stage that divides by 6 or by 5. A chain of down-counting decimal digits counts the pulses that the dual-modulus stage produces.

A three-digit decimal setting N selects the division ratio. The digits have weights 1, 10 and 100. The units digit S also acts as the swallow count. After each reload, the first S dual-modulus pulses come from divide-by-6 and the rest come from divide-by-5. When the chain finishes counting, the same enabled cycle reloads every counter from the digit inputs and toggles the output flip-flop. This makes `div_out` a square wave. Each of its half periods lasts 4 × (5·N + S) input clocks.

Top module: `pswl_divider`

## Requirements
- R1: A digit nibble above 9 is loaded as 9, so every counter digit stays in the range 0..9. For example, units 15, tens 12 and hundreds 0 behave exactly like 9, 9, 0.
- R2: The fixed first stage gives exactly one enable every 4 input clocks, and it never gives enables on two cycles in a row.
- R3: With `mod_sel` high, a dual-modulus period lasts 6 enables (24 clocks). With `mod_sel` low, it lasts 5 enables (20 clocks).
- R4: `mod_sel` goes high at each reload when the clamped units digit S is non-zero. It stays high for exactly S dual-modulus pulses, which is 24·S clocks. It changes only on a dual-modulus pulse or at reset.
- R5: `div_out` toggles once per count cycle, on the clock edge where the chain finishes. The span between toggles is 4 × (5·N + S) clocks, where N = 100·hundreds + 10·tens + units after clamping.
- R6: A setting of all zero digits counts 1000 dual-modulus pulses, which gives a toggle span of 20000 clocks.
- R7: While `rst` is high on a clock edge, the stage counters clear, `div_out` goes to 0 and the digits load. This makes `mod_sel` high exactly when S is non-zero. The first toggle comes 4 × (5·N + S) clocks after the first edge with `rst` low.
- R8: A change on `dig_bcd` during a count cycle does not change that cycle. It takes effect only at the next reload.
- R9: The reload happens in the finishing cycle itself, so consecutive toggle spans of a fixed setting are equal and no input pulse is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset; it also loads the digits |
| dig_bcd | input | 12 | Decimal setting. Bits 3:0 hold the units (also the swallow count), bits 7:4 the tens and bits 11:8 the hundreds |
| div_out | output | 1 | Square-wave divider output |
| mod_sel | output | 1 | Modulus control: 1 selects divide-by-6 |

## Verification
On every cycle, the assertions check these properties. Counter digits stay in decimal range. The first-stage enable is never high on two cycles in a row. The dual-modulus counter restarts after each of its pulses. `mod_sel` holds still between dual-modulus pulses, and at each reload it takes the value set by the units digit. `div_out` changes exactly on the finishing cycles. Only the bench scenarios can show the whole-cycle arithmetic. That arithmetic covers the toggle spans for several settings, how long `mod_sel` stays high, the wrap-around at an all-zero setting, clamping, reset in the middle of a count, and digit changes that wait for the next reload.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

   localparam int DIGIT_W = 4;

   typedef logic [DIGIT_W-1:0] bcd_t;

   // Force any nibble above nine down to nine.
   function automatic bcd_t clamp_digit(input bcd_t raw);
      return (raw > 4'd9) ? 4'd9 : raw;
   endfunction

endpackage

// File: rtl/pswl_prescale.sv
module pswl_prescale #(
   parameter int PRE_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic en
);
   localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
   localparam bit IS_POW2 = ((PRE_DIV & (PRE_DIV - 1)) == 0);

   if (PRE_DIV < 2) begin : g_bad_div
      $error("pswl_prescale: PRE_DIV must be at least 2");
   end

   logic [PW-1:0] cnt;

   if (IS_POW2) begin : g_pow2
      // Free-running wrap, terminal when all ones
      always_ff @(posedge clk) begin
         if (rst) cnt <= '0;
         else     cnt <= cnt + 1'b1;
      end
      assign en = &cnt;
   end else begin : g_modn
      always_ff @(posedge clk) begin
         if (rst || cnt == LAST) cnt <= '0;
         else                    cnt <= cnt + 1'b1;
      end
      assign en = (cnt == LAST);
   end

   // R2: enable is a lone single-cycle strobe
   p_pre_gap_r2: assert property (@(posedge clk) disable iff (rst)
      en |=> !en);

   // R2: counter restarts after each strobe
   p_pre_restart_r2: assert property (@(posedge clk) disable iff (rst)
      en |=> cnt == '0);

endmodule

// File: rtl/pswl_dualmod.sv
module pswl_dualmod #(
   parameter int MOD_LO = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic mod_hi,
   output logic pulse
);
   localparam int CW = $clog2(MOD_LO + 1);
   localparam logic [CW-1:0] TERM_LO = CW'(MOD_LO - 1);
   localparam logic [CW-1:0] TERM_HI = CW'(MOD_LO);

   if (MOD_LO < 2) begin : g_bad_mod
      $error("pswl_dualmod: MOD_LO must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] term;

   assign term  = mod_hi ? TERM_HI : TERM_LO;
   assign pulse = en && (cnt == term);

   always_ff @(posedge clk) begin
      if (rst || pulse) cnt <= '0;
      else if (en)      cnt <= cnt + 1'b1;
   end

   // R3: a new dual-modulus period starts at zero
   p_dm_restart_r3: assert property (@(posedge clk) disable iff (rst)
      pulse |=> cnt == '0);

   // R3: counter never passes the high modulus terminal
   p_dm_range_r3: assert property (@(posedge clk) disable iff (rst)
      cnt <= TERM_HI);

   // R3: counter moves only on enables
   p_dm_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(cnt));

endmodule

// File: rtl/pswl_decade.sv
module pswl_decade
   import pswl_pkg::*;
(
   input  logic clk,
   input  logic load,
   input  bcd_t din,
   input  logic dec,
   output bcd_t val,
   output logic is_zero,
   output logic is_one
);

   always_ff @(posedge clk) begin
      if (load)     val <= din;
      else if (dec) val <= (val == 4'd0) ? 4'd9 : val - 4'd1;
   end

   assign is_zero = (val == 4'd0);
   assign is_one  = (val == 4'd1);

   // R1: a digit never holds an illegal decimal code
   p_bcd_legal_r1: assert property (@(posedge clk) disable iff (load)
      val <= 4'd9);

   // R8: a digit moves only on load or decrement
   p_bcd_hold_r8: assert property (@(posedge clk) disable iff (load)
      !dec |=> $stable(val));

endmodule

// File: rtl/pswl_divider.sv
module pswl_divider
   import pswl_pkg::*;
#(
   parameter int PRE_DIV = 4,
   parameter int MOD_LO  = 5,
   parameter int NDIG    = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NDIG*DIGIT_W-1:0] dig_bcd,
   output logic                    div_out,
   output logic                    mod_sel
);

   if (NDIG < 1) begin : g_bad_ndig
      $error("pswl_divider: NDIG must be at least 1");
   end

   logic                     pre_en;
   logic                     dm_pulse;
   logic [NDIG-1:0][DIGIT_W-1:0] load_val;
   logic [NDIG-1:0][DIGIT_W-1:0] cnt_val;
   logic [NDIG-1:0]          dig_zero;
   logic [NDIG-1:0]          dig_one;
   logic [NDIG-1:0]          step;
   logic                     upper_zero;
   logic                     at_one;
   logic                     eoc;
   logic                     reload;
   bcd_t                     sw_val;
   logic                     sw_zero;
   logic                     sw_one;

   // Fixed first stage
   pswl_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk (clk),
      .rst (rst),
      .en  (pre_en)
   );

   // Dual-modulus stage
   pswl_dualmod #(.MOD_LO(MOD_LO)) u_dm (
      .clk    (clk),
      .rst    (rst),
      .en     (pre_en),
      .mod_hi (mod_sel),
      .pulse  (dm_pulse)
   );

   // Borrow chain: a digit steps when all lower digits are zero
   always_comb begin
      logic low_z;
      low_z = 1'b1;
      for (int i = 0; i < NDIG; i++) begin
         step[i] = dm_pulse && low_z;
         low_z   = low_z && dig_zero[i];
      end
   end

   always_comb begin
      upper_zero = 1'b1;
      for (int i = 1; i < NDIG; i++) begin
         upper_zero = upper_zero && dig_zero[i];
      end
   end

   // Finish when the chain is about to reach all-zero
   assign at_one = dig_one[0] && upper_zero;
   assign eoc    = dm_pulse && at_one;
   assign reload = rst || eoc;

   for (genvar g = 0; g < NDIG; g++) begin : g_digit
      assign load_val[g] = clamp_digit(dig_bcd[g*DIGIT_W +: DIGIT_W]);

      pswl_decade u_dig (
         .clk     (clk),
         .load    (reload),
         .din     (load_val[g]),
         .dec     (step[g]),
         .val     (cnt_val[g]),
         .is_zero (dig_zero[g]),
         .is_one  (dig_one[g])
      );
   end

   // Swallow counter, preset from the units digit
   pswl_decade u_swallow (
      .clk     (clk),
      .load    (reload),
      .din     (load_val[0]),
      .dec     (dm_pulse && !sw_zero),
      .val     (sw_val),
      .is_zero (sw_zero),
      .is_one  (sw_one)
   );

   assign mod_sel = !sw_zero;

   // Output flip-flop
   always_ff @(posedge clk) begin
      if (rst)      div_out <= 1'b0;
      else if (eoc) div_out <= !div_out;
   end

   // R5: output flips on each finishing cycle
   p_toggle_eoc_r5: assert property (@(posedge clk) disable iff (rst)
      eoc |=> div_out != $past(div_out));

   // R5: output holds between finishing cycles
   p_hold_out_r5: assert property (@(posedge clk) disable iff (rst)
      !eoc |=> $stable(div_out));

   // R4: modulus control moves only on dual-modulus pulses
   p_modsel_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !dm_pulse |=> $stable(mod_sel));

   // R4: after reload, modulus control follows the units digit
   p_modsel_reload_r4: assert property (@(posedge clk) disable iff (rst)
      eoc |=> mod_sel == ($past(dig_bcd[DIGIT_W-1:0]) != 4'd0));

   // R9: the chain reloads with the new setting in the finishing cycle
   p_reload_units_r9: assert property (@(posedge clk) disable iff (rst)
      eoc |=> cnt_val[0] == clamp_digit($past(dig_bcd[DIGIT_W-1:0])));

   // R2: dual-modulus pulses only on first-stage enables
   p_dm_on_en_r2: assert property (@(posedge clk) disable iff (rst)
      dm_pulse |-> pre_en);

   // R4: swallow one-state is a one-pulse warning for mod_sel fall
   p_sw_fall_r4: assert property (@(posedge clk) disable iff (rst)
      (sw_one && dm_pulse && !eoc) |=> !mod_sel);

endmodule

// File: tb/pswl_divider_bench.sv
module pswl_divider_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] dig_bcd = 12'h000;
   logic        div_out;
   logic        mod_sel;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pswl_divider u_pswl_divider (
      .clk     (clk),
      .rst     (rst),
      .dig_bcd (dig_bcd),
      .div_out (div_out),
      .mod_sel (mod_sel)
   );

   // Fields: ones, tens, hundreds, expected span, expected mod_sel-high clocks
   localparam logic [47:0] VEC [8] = '{
      {4'd3,  4'd2,  4'd1, 20'd2472,  16'd72},
      {4'd0,  4'd0,  4'd1, 20'd2000,  16'd0},
      {4'd9,  4'd9,  4'd0, 20'd2016,  16'd216},
      {4'd5,  4'd0,  4'd0, 20'd120,   16'd120},
      {4'd1,  4'd0,  4'd0, 20'd24,    16'd24},
      {4'd15, 4'd12, 4'd0, 20'd2016,  16'd216},
      {4'd0,  4'd0,  4'd0, 20'd20000, 16'd0},
      {4'd7,  4'd4,  4'd2, 20'd4968,  16'd168}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [11:0] d);
      @(negedge clk);
      dig_bcd = d;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // From a negedge: count clocks to the next div_out change and mod_sel-high clocks
   task automatic measure(output int n, output int m);
      logic prev;
      prev = div_out;
      n = 0;
      m = 0;
      while (n < 30000) begin
         if (mod_sel) m++;
         @(posedge clk);
         n++;
         @(negedge clk);
         if (div_out !== prev) break;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n, m;
      // R7: reset state
      @(negedge clk);
      dig_bcd = {4'd1, 4'd2, 4'd3};
      repeat (2) @(negedge clk);
      check(div_out == 1'b0, "R7 div_out in reset", int'(div_out), 0);
      check(mod_sel == 1'b1, "R7 mod_sel in reset", int'(mod_sel), 1);

      // Vector table: R1 R2 R3 R4 R5 R6 R9
      foreach (VEC[i]) begin
         logic [3:0] o, t, h;
         int exp_n, exp_m;
         {o, t, h} = VEC[i][47:36];
         exp_n = int'(VEC[i][35:16]);
         exp_m = int'(VEC[i][15:0]);
         do_reset({h, t, o});
         check(mod_sel == (o != 0), "R7 R4 mod_sel after reset", int'(mod_sel), int'(o != 0));
         measure(n, m);
         check(n == exp_n, "R5 R2 R1 R6 first span", n, exp_n);
         check(m == exp_m, "R4 R3 first mod_sel time", m, exp_m);
         measure(n, m);
         check(n == exp_n, "R9 second span", n, exp_n);
         check(m == exp_m, "R4 R3 second mod_sel time", m, exp_m);
      end

      // R8: digits changed mid-cycle take effect only at reload
      do_reset({4'd0, 4'd0, 4'd1});
      repeat (10) @(negedge clk);
      dig_bcd = {4'd1, 4'd2, 4'd3};
      measure(n, m);
      // 10 clocks already elapsed before measuring
      check(n == 14, "R8 current span unchanged", n, 14);
      measure(n, m);
      check(n == 2472, "R8 new setting after reload", n, 2472);
      check(m == 72, "R8 new swallow after reload", m, 72);

      // R7: reset in the middle of a count restarts the cycle
      do_reset({4'd2, 4'd4, 4'd7});
      repeat (300) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(div_out == 1'b0, "R7 mid-count reset output", int'(div_out), 0);
      rst = 1'b0;
      measure(n, m);
      check(n == 4968, "R7 span after mid-count reset", n, 4968);

      // R1: all-nines clamp on every nibble
      do_reset(12'hFFF);
      measure(n, m);
      check(n == 4 * (5 * 999 + 9), "R1 clamped 999 span", n, 4 * (5 * 999 + 9));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule